// File: doc/BRIEF.md
# Etherbone Record Engine for a Wishbone Master

The engine reads an Etherbone request stream as 32-bit words from an external word buffer and runs each record as Wishbone master accesses. It returns a response stream with one output word for every input word it consumes. The first two words of a stream are the probe. The engine answers them with a fixed probe-response word, followed by an echo of the second word. Every later record starts with a header word. The engine performs the record's writes, reads the requested addresses, and rewrites the record into a response record that carries the read data.

The buffer sits outside the engine. It shows the engine the word at its head (`in_data_i`) and the number of words it holds (`in_avail_i`). The engine removes the head word by asserting `in_pop_o`. Reads flagged as configuration reads are served from a small local space on `cfg_i` and do not go to the bus. The bus cycle line can stay open across several records. It closes after a record whose end-of-cycle flag is set, or when the stream is closed.

Top module: `eb_wb_engine`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `out_valid_o` and `in_pop_o` are low, and the byte-lane select is 0xF.
- R2: In the probe state, the engine waits until at least two words are available. It then emits 0x4E6F1244 (the bytes 0x4E, 0x6F, 0x12, then the address size in bytes in the upper nibble and the data size in bytes in the lower nibble), followed by the second input word unchanged. After that it expects record headers.
- R3: A record header holds four bytes, from bit 31 down to bit 0: flags, byte enable, write count (wc), read count (rc). The record spans 1 + wc + rc + (wc>0) + (rc>0) words. No word of the record is consumed and no access starts until `in_avail_i` reaches that length.
- R4: When wc>0, the word after the header is the write base address, and the next wc words are written to the bus one by one. The address rises by 4 after each write, unless flag bit 1 (fixed write address) is set, in which case every write goes to the base address.
- R5: With flag bit 2 (skip writes) set, no bus write is made, but the write words are still consumed and answered exactly as in R6.
- R6: Each word of the write section (header, base and data) is answered with zero, except the last one, which carries the response header. When wc=0, the response header replaces the header itself. The response header is built as follows: flag bit 3 is kept, flag bit 5 moves to bit 1, flag bit 7 moves to bit 2, and all other flag bits are 0. The byte enable is kept, rc moves into the write-count byte, and the low byte is 0.
- R7: When rc>0, the return-address word is passed through unchanged. Each following address word is answered with the data read from the bus at that address, with `wb_we_o` low.
- R8: With flag bit 6 set, reads go to the local config space of N_CFG words at byte addresses 0, 4, 8 and up; any other address reads 0. No bus access is made.
- R9: `wb_cyc_o` rises when a record starts while no cycle is open. It stays high across records whose flag bit 3 is clear, and it falls after the last word of a record with flag bit 3 set. `wb_stb_o` is only high while `wb_cyc_o` is high.
- R10: `close_i` drops `wb_cyc_o` and `wb_stb_o` on the next edge and returns the engine to the probe state.
- R11: Only one access is outstanding at a time. `wb_stb_o`, address, write enable and write data stay stable until `wb_ack_i` arrives, and no output word is offered while the access is pending.
- R12: Only byte enables 0x1, 0x2, 0x4, 0x8, 0x3, 0xC and 0xF load `wb_sel_o`. Any other mask leaves the select from the previous record in place.
- R13: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds. An input word is popped exactly when its output word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| close_i | input | 1 | Stream closed; drop cycle, restart at probe |
| in_data_i | input | 32 | Word at the head of the request buffer |
| in_avail_i | input | AVAIL_W | Words held in the request buffer |
| in_pop_o | output | 1 | Remove the head word |
| out_data_o | output | 32 | Response word |
| out_valid_o | output | 1 | Response word valid |
| out_ready_i | input | 1 | Response word accepted |
| cfg_i | input | N_CFG*32 | Local config words, word k at bits k*32 and up |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | ADR_W | Bus byte address |
| wb_sel_o | output | 4 | Bus byte-lane select |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Two cycle-line events can fall on adjacent edges: the close at the end of one record, and the reopen at the start of the next record when that record is already fully buffered. The bench queues two back-to-back records that both carry the end-of-cycle flag, with the second one waiting in the buffer. It counts the rising edges of `wb_cyc_o`, sampled mid-cycle. The count must grow by one for each record, which proves the line was seen low between them. Meanwhile every bus access must be observed with the cycle line high.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 10;

  localparam int FL_BCA = 7;
  localparam int FL_RCA = 6;
  localparam int FL_RFF = 5;
  localparam int FL_CYC = 3;
  localparam int FL_WCA = 2;
  localparam int FL_WFF = 1;

  typedef struct packed {
    logic [7:0] flags;
    logic [7:0] be;
    logic [7:0] wcnt;
    logic [7:0] rcnt;
  } rec_hdr_t;

  typedef enum logic [2:0] {
    ST_PRB_WAIT, ST_PRB_HDR, ST_PRB_LOAD, ST_PRB_ECHO,
    ST_WAIT, ST_WORD, ST_BUS, ST_EMIT
  } eng_state_t;

  function automatic logic [LEN_W-1:0] rec_len(rec_hdr_t h);
    return LEN_W'(1) + LEN_W'(h.wcnt) + LEN_W'(h.rcnt)
         + LEN_W'(h.wcnt != 0) + LEN_W'(h.rcnt != 0);
  endfunction

  function automatic logic be_ok(logic [7:0] be);
    return be inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h03, 8'h0C, 8'h0F};
  endfunction
endpackage

// File: rtl/eb_rec_decode.sv
module eb_rec_decode
  import eb_pkg::*;
(
  input  rec_hdr_t          hdr_i,
  output logic [LEN_W-1:0]  wlen_o,
  output logic [LEN_W-1:0]  tlen_o,
  output logic [WORD_W-1:0] resp_o,
  output logic              wca_o,
  output logic              rca_o,
  output logic              wff_o,
  output logic              end_o
);
  logic [7:0] rflags;
  logic       unused_flags;

  assign unused_flags = ^{hdr_i.flags[4], hdr_i.flags[0]};

  // write section: header + base + data, or just the header
  assign wlen_o = (hdr_i.wcnt != 0) ? LEN_W'(hdr_i.wcnt) + LEN_W'(2) : LEN_W'(1);
  assign tlen_o = wlen_o + ((hdr_i.rcnt != 0) ? LEN_W'(hdr_i.rcnt) + LEN_W'(1) : '0);

  always_comb begin
    rflags         = '0;
    rflags[FL_CYC] = hdr_i.flags[FL_CYC];
    rflags[FL_WFF] = hdr_i.flags[FL_RFF];
    rflags[FL_WCA] = hdr_i.flags[FL_BCA];
  end

  assign resp_o = {rflags, hdr_i.be, hdr_i.rcnt, 8'h00};
  assign wca_o  = hdr_i.flags[FL_WCA];
  assign rca_o  = hdr_i.flags[FL_RCA];
  assign wff_o  = hdr_i.flags[FL_WFF];
  assign end_o  = hdr_i.flags[FL_CYC];
endmodule

// File: rtl/eb_cfg_space.sv
module eb_cfg_space
  import eb_pkg::*;
#(
  parameter int N_CFG = 4
) (
  input  logic [WORD_W-1:0]       addr_i,
  input  logic [N_CFG*WORD_W-1:0] cfg_i,
  output logic [WORD_W-1:0]       data_o
);
  logic [WORD_W-1:0] term [N_CFG];

  for (genvar k = 0; k < N_CFG; k++) begin : g_word
    assign term[k] = (addr_i == WORD_W'(k * 4)) ? cfg_i[k*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    data_o = '0;
    for (int k = 0; k < N_CFG; k++) data_o = data_o | term[k];
  end
endmodule

// File: rtl/eb_wb_engine.sv
module eb_wb_engine
  import eb_pkg::*;
#(
  parameter int ADR_W   = 32,
  parameter int AVAIL_W = 12,
  parameter int N_CFG   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    close_i,
  input  logic [WORD_W-1:0]       in_data_i,
  input  logic [AVAIL_W-1:0]      in_avail_i,
  output logic                    in_pop_o,
  output logic [WORD_W-1:0]       out_data_o,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  input  logic [N_CFG*WORD_W-1:0] cfg_i,
  output logic                    wb_cyc_o,
  output logic                    wb_stb_o,
  output logic                    wb_we_o,
  output logic [ADR_W-1:0]        wb_adr_o,
  output logic [3:0]              wb_sel_o,
  output logic [WORD_W-1:0]       wb_dat_o,
  input  logic [WORD_W-1:0]       wb_dat_i,
  input  logic                    wb_ack_i
);
  localparam logic [7:0]        SIZE_BYTE  = {4'(ADR_W / 8), 4'(WORD_W / 8)};
  localparam logic [WORD_W-1:0] PROBE_WORD = {8'h4E, 8'h6F, 8'h12, SIZE_BYTE};

  eng_state_t        st_q;
  rec_hdr_t          hdr_q, hdr_in;
  logic [LEN_W-1:0]  pos_q, wlen, tlen, in_len;
  logic [WORD_W-1:0] out_q, resp, cfg_rd, bdat_q;
  logic [ADR_W-1:0]  wadr_q, badr_q;
  logic              bwe_q, cyc_q;
  logic [3:0]        sel_q;
  logic              f_wca, f_rca, f_wff, f_end, rec_fits, fire, last;

  assign hdr_in   = rec_hdr_t'(in_data_i);
  assign in_len   = rec_len(hdr_in);
  assign rec_fits = (in_avail_i != '0) && (32'(in_avail_i) >= 32'(in_len));

  eb_rec_decode u_dec (
    .hdr_i (hdr_q), .wlen_o(wlen), .tlen_o(tlen), .resp_o(resp),
    .wca_o (f_wca), .rca_o(f_rca), .wff_o(f_wff), .end_o(f_end)
  );

  eb_cfg_space #(.N_CFG(N_CFG)) u_cfg (
    .addr_i(in_data_i), .cfg_i(cfg_i), .data_o(cfg_rd)
  );

  assign out_valid_o = (st_q == ST_PRB_HDR) || (st_q == ST_PRB_ECHO) || (st_q == ST_EMIT);
  assign out_data_o  = out_q;
  assign fire        = out_valid_o && out_ready_i;
  assign in_pop_o    = fire && !close_i;
  assign last        = (pos_q == tlen - LEN_W'(1));

  assign wb_cyc_o = cyc_q;
  assign wb_stb_o = (st_q == ST_BUS);
  assign wb_we_o  = bwe_q;
  assign wb_adr_o = badr_q;
  assign wb_sel_o = sel_q;
  assign wb_dat_o = bdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PRB_WAIT;
      hdr_q  <= '0;
      pos_q  <= '0;
      out_q  <= '0;
      wadr_q <= '0;
      badr_q <= '0;
      bdat_q <= '0;
      bwe_q  <= 1'b0;
      cyc_q  <= 1'b0;
      sel_q  <= 4'hF;
    end else if (close_i) begin
      st_q  <= ST_PRB_WAIT;
      cyc_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_PRB_WAIT:
          if (32'(in_avail_i) >= 32'd2) begin
            out_q <= PROBE_WORD;
            st_q  <= ST_PRB_HDR;
          end
        ST_PRB_HDR:  if (out_ready_i) st_q <= ST_PRB_LOAD;
        ST_PRB_LOAD: begin
          out_q <= in_data_i;
          st_q  <= ST_PRB_ECHO;
        end
        ST_PRB_ECHO: if (out_ready_i) st_q <= ST_WAIT;
        ST_WAIT:
          if (rec_fits) begin
            hdr_q <= hdr_in;
            pos_q <= '0;
            cyc_q <= 1'b1;
            if (be_ok(hdr_in.be)) sel_q <= hdr_in.be[3:0];
            st_q  <= ST_WORD;
          end
        ST_WORD: begin
          st_q <= ST_EMIT;
          if (pos_q < wlen) begin
            if (hdr_q.wcnt == 0) out_q <= resp;
            else if (pos_q == 0) out_q <= '0;
            else if (pos_q == 1) begin
              out_q  <= '0;
              wadr_q <= in_data_i[ADR_W-1:0];
            end else begin
              out_q <= (pos_q == wlen - LEN_W'(1)) ? resp : '0;
              if (!f_wca) begin
                bwe_q  <= 1'b1;
                badr_q <= wadr_q;
                bdat_q <= in_data_i;
                st_q   <= ST_BUS;
              end
            end
          end else if (pos_q == wlen) out_q <= in_data_i;   // return address
          else if (f_rca) out_q <= cfg_rd;
          else begin
            bwe_q  <= 1'b0;
            badr_q <= in_data_i[ADR_W-1:0];
            st_q   <= ST_BUS;
          end
        end
        ST_BUS:
          if (wb_ack_i) begin
            if (!bwe_q) out_q <= wb_dat_i;
            else if (!f_wff) wadr_q <= wadr_q + ADR_W'(4);
            st_q <= ST_EMIT;
          end
        ST_EMIT:
          if (out_ready_i) begin
            if (last) begin
              st_q <= ST_WAIT;
              if (f_end) cyc_q <= 1'b0;
            end else begin
              pos_q <= pos_q + LEN_W'(1);
              st_q  <= ST_WORD;
            end
          end
        default: st_q <= ST_PRB_WAIT;
      endcase
    end
  end

  p_stb_in_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);
  p_close_drops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> !wb_cyc_o && !wb_stb_o);
  p_stb_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && !wb_ack_i && !close_i |=>
      wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o));
  p_out_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !close_i |=> out_valid_o && $stable(out_data_o));
  p_pop_avail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop_o |-> in_avail_i != '0);
  p_sel_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o |-> be_ok({4'h0, wb_sel_o}));
endmodule

// File: tb/eb_wb_engine_tb_top.sv
`timescale 1ns/1ps
module eb_wb_engine_tb_top;
  localparam int AVAIL_W = 12;
  localparam int N_CFG   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic close_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic [AVAIL_W-1:0] in_avail_i = '0;
  logic in_pop_o;
  logic [31:0] out_data_o;
  logic out_valid_o;
  logic out_ready_i = 1'b0;
  logic [N_CFG*32-1:0] cfg_i;
  logic wb_cyc_o, wb_stb_o, wb_we_o;
  logic [31:0] wb_adr_o, wb_dat_o;
  logic [3:0] wb_sel_o;
  logic [31:0] wb_dat_i = '0;
  logic wb_ack_i = 1'b0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
    assign cfg_i[k*32 +: 32] = 32'hC0DE_0000 + 32'(k);
  end

  eb_wb_engine #(.ADR_W(32), .AVAIL_W(AVAIL_W), .N_CFG(N_CFG)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .close_i(close_i),
    .in_data_i(in_data_i), .in_avail_i(in_avail_i), .in_pop_o(in_pop_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .cfg_i(cfg_i), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
    .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o),
    .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] in_q[$];
  logic [31:0] exp_q[$];
  string       exp_tag[$];
  logic        bx_we[$];
  logic [31:0] bx_adr[$], bx_dat[$];
  logic [3:0]  bx_sel[$];
  string       bx_tag[$];
  logic [3:0]  model_sel = 4'hF;
  bit   pop_pending = 0, cyc_prev = 0, done = 0;
  int   cyc_rises = 0, cyc_cnt = 0, nacc = 0, ack_wait = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic bit mask_legal(input logic [7:0] be);
    return be == 8'h01 || be == 8'h02 || be == 8'h04 || be == 8'h08 ||
           be == 8'h03 || be == 8'h0C || be == 8'h0F;
  endfunction

  // driver: builds a record, pushes expected responses and bus accesses
  task automatic send_record(input logic [7:0] fl, input logic [7:0] be, input int wc,
                             input int rc, input logic [31:0] base, input logic [31:0] ret,
                             input int split);
    logic [31:0] w[$];
    logic [31:0] a;
    logic [7:0]  rf;
    logic [31:0] resp;
    string       btag;
    rf = {5'b0, fl[7], fl[5], 1'b0} | (fl & 8'h08);
    resp = {rf, be, 8'(rc), 8'h00};
    btag = mask_legal(be) ? "R4" : "R12";
    if (mask_legal(be)) model_sel = be[3:0];
    w.push_back({fl, be, 8'(wc), 8'(rc)});
    if (wc > 0) begin
      w.push_back(base);
      a = base;
      for (int k = 0; k < wc; k++) begin
        w.push_back(32'hD000_0000 + base + 32'(k));
        if (!fl[2]) begin
          bx_we.push_back(1'b1); bx_adr.push_back(a);
          bx_dat.push_back(32'hD000_0000 + base + 32'(k));
          bx_sel.push_back(model_sel); bx_tag.push_back(btag);
        end
        if (!fl[1]) a = a + 4;
      end
      for (int k = 0; k <= wc; k++) begin
        exp_q.push_back('0); exp_tag.push_back(fl[2] ? "R5" : "R6");
      end
    end
    exp_q.push_back(resp); exp_tag.push_back("R6");
    if (rc > 0) begin
      w.push_back(ret);
      exp_q.push_back(ret); exp_tag.push_back("R7");
      for (int k = 0; k < rc; k++) begin
        if (fl[6]) begin
          a = 32'(k * 8 + 4);
          w.push_back(a);
          exp_q.push_back(a < 32'(N_CFG * 4) ? 32'hC0DE_0000 + (a >> 2) : 32'h0);
          exp_tag.push_back("R8");
        end else begin
          a = 32'h0000_2000 + 32'(k * 8);
          w.push_back(a);
          bx_we.push_back(1'b0); bx_adr.push_back(a); bx_dat.push_back('0);
          bx_sel.push_back(model_sel); bx_tag.push_back("R7");
          exp_q.push_back(rd_model(a)); exp_tag.push_back("R7");
        end
      end
    end
    if (split > 0 && split < w.size()) begin
      for (int k = 0; k < split; k++) in_q.push_back(w[k]);
      repeat (15) @(posedge clk);
      #1;
      chk(!out_valid_o && !wb_stb_o, "R3 partial record started", 32'(out_valid_o), 32'h0);
      chk(in_q.size() == split, "R3 partial record consumed", 32'(in_q.size()), 32'(split));
      for (int k = split; k < w.size(); k++) in_q.push_back(w[k]);
    end else begin
      foreach (w[k]) in_q.push_back(w[k]);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || bx_we.size() != 0 || in_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  // input driver, bus slave and monitor, all away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (pop_pending) begin
        void'(in_q.pop_front());
        pop_pending = 0;
      end
      in_avail_i  = AVAIL_W'(in_q.size());
      in_data_i   = (in_q.size() != 0) ? in_q[0] : 32'h0;
      out_ready_i = (cyc_cnt % 5) != 4;
      cyc_cnt++;
      wb_ack_i = 1'b0;
      #1;
      if (rst_ni) begin
        if (wb_cyc_o && !cyc_prev) cyc_rises++;
        cyc_prev = wb_cyc_o;
        if (out_valid_o && out_ready_i && !close_i) begin
          chk(in_pop_o, "R13 pop with accept", 32'(in_pop_o), 32'h1);
          if (exp_q.size() == 0) chk(0, "R13 unexpected output", out_data_o, 32'h0);
          else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            chk(out_data_o == e, t, out_data_o, e);
          end
          pop_pending = 1;
        end
        if (wb_stb_o) begin
          chk(!out_valid_o && wb_cyc_o, "R11 output during access", 32'(out_valid_o), 32'h0);
          if (ack_wait >= nacc % 3) begin
            wb_ack_i = 1'b1;
            wb_dat_i = wb_we_o ? 32'h0 : rd_model(wb_adr_o);
            ack_wait = 0;
            nacc++;
            if (bx_we.size() == 0) chk(0, "R11 unexpected access", wb_adr_o, 32'h0);
            else begin
              logic we;
              logic [31:0] ad, dt;
              logic [3:0] sl;
              string t;
              we = bx_we.pop_front(); ad = bx_adr.pop_front(); dt = bx_dat.pop_front();
              sl = bx_sel.pop_front(); t = bx_tag.pop_front();
              chk(wb_we_o == we && wb_adr_o == ad && wb_sel_o == sl && (!we || wb_dat_o == dt),
                  t, {wb_adr_o[23:0], 3'b0, wb_we_o, wb_sel_o}, {ad[23:0], 3'b0, we, sl});
            end
          end else ack_wait++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 32'(cyc_cnt), 32'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(!wb_cyc_o && !wb_stb_o && !out_valid_o && !in_pop_o, "R1 reset outputs",
        {28'h0, wb_cyc_o, wb_stb_o, out_valid_o, in_pop_o}, 32'h0);
    chk(wb_sel_o == 4'hF, "R1 reset select", 32'(wb_sel_o), 32'hF);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 probe needs two words
    @(posedge clk);
    in_q.push_back(32'hAABB_CCDD);
    repeat (10) @(posedge clk);
    #1;
    chk(!out_valid_o, "R2 probe with one word", 32'(out_valid_o), 32'h0);
    exp_q.push_back(32'h4E6F_1244); exp_tag.push_back("R2");
    exp_q.push_back(32'h1234_5678); exp_tag.push_back("R2");
    in_q.push_back(32'h1234_5678);
    drain();

    // R3 R4 R6 R7: split record, then fixed-address writes, skip + config reads, bad mask
    send_record(8'h00, 8'h0F, 2, 1, 32'h0000_0100, 32'h0000_7000, 4);
    send_record(8'h22, 8'h03, 3, 2, 32'h0000_0040, 32'h0000_7100, 0);
    send_record(8'hC4, 8'h05, 2, 3, 32'h0000_0300, 32'h0000_7200, 0);
    send_record(8'h08, 8'h0A, 1, 0, 32'h0000_0500, 32'h0, 0);
    drain();
    chk(cyc_rises == 1, "R9 one cycle across records", 32'(cyc_rises), 32'h1);
    chk(!wb_cyc_o, "R9 cycle closed by flag", 32'(wb_cyc_o), 32'h0);

    // back-to-back close and reopen
    send_record(8'h08, 8'h0C, 0, 0, 32'h0, 32'h0, 0);
    send_record(8'h08, 8'h0C, 0, 1, 32'h0, 32'h0000_7300, 0);
    drain();
    chk(cyc_rises == 3, "R9 reopen after close", 32'(cyc_rises), 32'h3);

    // cycle stays open, then stream close
    send_record(8'h20, 8'h01, 1, 1, 32'h0000_0600, 32'h0000_7400, 0);
    drain();
    chk(wb_cyc_o, "R9 cycle held open", 32'(wb_cyc_o), 32'h1);
    @(negedge clk);
    close_i = 1'b1;
    @(negedge clk);
    close_i = 1'b0;
    #1;
    chk(!wb_cyc_o && !wb_stb_o, "R10 close drops cycle", 32'(wb_cyc_o), 32'h0);
    @(posedge clk);
    exp_q.push_back(32'h4E6F_1244); exp_tag.push_back("R10");
    exp_q.push_back(32'h0BAD_F00D); exp_tag.push_back("R10");
    in_q.push_back(32'h0800_0000);
    in_q.push_back(32'h0BAD_F00D);
    drain();
    chk(in_q.size() == 0 && !out_valid_o, "R13 stream drained", 32'(in_q.size()), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule